// File: doc/BRIEF.md
# Register Window Controller

This block keeps the bookkeeping state for a windowed integer register file. It holds the current window pointer and four occupancy counters. The counters track how many windows may still be saved, how many may be restored, how many are known clean, and how many belong to another context. A six-bit window-state register sits beside them. Its low three bits are the normal trap field and its high three bits are the other trap field. The register file storage itself is not part of the block.

The pipeline presents one request per cycle with a valid strobe and a two-bit code. The codes are 0 = save, 1 = restore, 2 = return, 3 = flush-windows. The block commits the new window pointer and counters on the next clock edge. On that same edge it raises a one-cycle trap indication carrying a kind code, an other/normal flag and a three-bit vector field. A pointer step is still committed when a spill, fill or clean-window trap is raised, so the handler runs in the new window. Privileged software can overwrite any counter, the pointer or the window-state register through a select-addressed write port.

Top module: `regwin_unit`

## Requirements
- R1: After reset the outputs are: pointer 0, save counter NWIN-2, restore counter 0, clean counter NWIN-1, other counter 0, window-state 0, and no trap.
- R2: A save while the save counter is nonzero and the clean counter differs from the restore counter does three things on the next cycle: the pointer rises by 1 modulo NWIN, the save counter falls by 1 and the restore counter rises by 1. No trap is raised.
- R3: A save while the save counter is zero raises a spill trap (kind 1). The pointer rises by 2 modulo NWIN and the counters are unchanged. This check takes priority over the clean check in R4.
- R4: A save with a nonzero save counter and a clean counter equal to the restore counter raises a clean-window trap (kind 3). The pointer rises by 1 modulo NWIN and the counters are unchanged.
- R5: A restore moves the pointer down by 1, and pointer 0 wraps to NWIN-1. If the restore counter is zero, a fill trap (kind 2) is raised and the counters are unchanged. Otherwise the save counter rises by 1 and the restore counter falls by 1.
- R6: On a spill or fill trap the other flag is 1 and the vector is window-state bits [5:3] when the other counter is nonzero. Otherwise the flag is 0 and the vector is bits [2:0]. On clean-window and alignment traps the flag and the vector are 0.
- R7: A return whose two target low bits are not both zero raises an alignment trap (kind 4) and changes no state. A return with both bits zero acts exactly as a restore.
- R8: Flush-windows raises a spill trap, typed as in R6, when NWIN-2 minus the save counter is nonzero, and changes no state. When that difference is zero it does nothing.
- R9: A write with no request pending loads the selected register on the next cycle. The select codes are 0 pointer, 1 save, 2 restore, 3 clean, 4 other, 5 window-state. A write in a cycle with a valid request is ignored.
- R10: The trap valid output is high only in the cycle after a trapping request, and kind is 0 whenever valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 2 | Request code: 0 save, 1 restore, 2 return, 3 flush |
| retAddrLow | input | 2 | Low two bits of the return target address |
| wrEn | input | 1 | Privileged write strobe |
| wrSel | input | 3 | Write target select |
| wrData | input | 6 | Write value, taken from the low bits |
| cwp | output | 3 | Current window pointer |
| canSave | output | 3 | Save counter |
| canRestore | output | 3 | Restore counter |
| cleanWin | output | 3 | Clean counter |
| otherWin | output | 3 | Other counter |
| wState | output | 6 | Window-state register: [2:0] normal, [5:3] other |
| trapValid | output | 1 | Trap raised (one cycle) |
| trapKind | output | 3 | 0 none, 1 spill, 2 fill, 3 clean, 4 align |
| trapOther | output | 1 | Trap uses the other field |
| trapVec | output | 3 | Selected window-state field |

## Verification
Every result is due one clock after the request or write is presented: the pointer, the counters and the trap fields all come from a single register stage. The bench drives inputs just after a falling edge and advances its behavioural model for the rising edge that follows. It then compares every output with the model at the next falling edge, so each comparison lands on the first cycle in which the result is valid. Idle cycles are compared in the same way, which checks that trap pulses last one cycle and that state holds.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [1:0] {
    OP_SAVE    = 2'd0,
    OP_RESTORE = 2'd1,
    OP_RETURN  = 2'd2,
    OP_FLUSH   = 2'd3
  } reqOp_e;

  typedef enum logic [2:0] {
    TK_NONE  = 3'd0,
    TK_SPILL = 3'd1,
    TK_FILL  = 3'd2,
    TK_CLEAN = 3'd3,
    TK_ALIGN = 3'd4
  } trapKind_e;

  typedef enum logic [2:0] {
    SEL_CWP     = 3'd0,
    SEL_SAVE    = 3'd1,
    SEL_RESTORE = 3'd2,
    SEL_CLEAN   = 3'd3,
    SEL_OTHER   = 3'd4,
    SEL_WSTATE  = 3'd5
  } wrSel_e;

  // Strobes from control to datapath, all for the coming clock edge.
  typedef struct packed {
    logic      cwpUp1;
    logic      cwpUp2;
    logic      cwpDown1;
    logic      shiftSave;     // save counter -1, restore counter +1
    logic      shiftRestore;  // save counter +1, restore counter -1
    logic      trapFire;
    trapKind_e trapKind;
    logic      trapOther;
    logic      wrApply;
  } winStrobe_t;

endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic          reqValid,
  input  logic [1:0]    reqOp,
  input  logic [1:0]    retAddrLow,
  input  logic          wrEn,
  input  logic [CW-1:0] canSave,
  input  logic [CW-1:0] canRestore,
  input  logic [CW-1:0] cleanWin,
  input  logic [CW-1:0] otherWin,
  output winStrobe_t    stb
);

  logic saveSpill, saveClean, restoreFill, flushPending, misaligned, otherSel;
  reqOp_e opCode;

  assign opCode       = reqOp_e'(reqOp);
  assign saveSpill    = (canSave == '0);
  assign saveClean    = (cleanWin == canRestore);
  assign restoreFill  = (canRestore == '0);
  // NWIN-2-canSave is nonzero exactly when canSave differs from NWIN-2
  assign flushPending = (canSave != CW'(NWIN - 2));
  assign misaligned   = (retAddrLow != 2'b00);
  assign otherSel     = (otherWin != '0);

  always_comb begin
    stb          = '0;
    stb.trapKind = TK_NONE;
    if (reqValid) begin
      unique case (opCode)
        OP_SAVE: begin
          if (saveSpill) begin
            stb.cwpUp2    = 1'b1;
            stb.trapFire  = 1'b1;
            stb.trapKind  = TK_SPILL;
            stb.trapOther = otherSel;
          end else if (saveClean) begin
            stb.cwpUp1   = 1'b1;
            stb.trapFire = 1'b1;
            stb.trapKind = TK_CLEAN;
          end else begin
            stb.cwpUp1    = 1'b1;
            stb.shiftSave = 1'b1;
          end
        end
        OP_RESTORE, OP_RETURN: begin
          if (opCode == OP_RETURN && misaligned) begin
            stb.trapFire = 1'b1;
            stb.trapKind = TK_ALIGN;
          end else begin
            stb.cwpDown1 = 1'b1;
            if (restoreFill) begin
              stb.trapFire  = 1'b1;
              stb.trapKind  = TK_FILL;
              stb.trapOther = otherSel;
            end else begin
              stb.shiftRestore = 1'b1;
            end
          end
        end
        OP_FLUSH: begin
          if (flushPending) begin
            stb.trapFire  = 1'b1;
            stb.trapKind  = TK_SPILL;
            stb.trapOther = otherSel;
          end
        end
        default: ;
      endcase
    end else if (wrEn) begin
      stb.wrApply = 1'b1;
    end
  end

endmodule

// File: rtl/regwin_dp.sv
module regwin_dp
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int WSW  = 3,
  localparam int CW  = $clog2(NWIN),
  localparam int WDW = (CW > 2 * WSW) ? CW : 2 * WSW
) (
  input  logic             clk,
  input  logic             rst,
  input  winStrobe_t       stb,
  input  logic [2:0]       wrSel,
  input  logic [WDW-1:0]   wrData,
  output logic [CW-1:0]    cwp,
  output logic [CW-1:0]    canSave,
  output logic [CW-1:0]    canRestore,
  output logic [CW-1:0]    cleanWin,
  output logic [CW-1:0]    otherWin,
  output logic [2*WSW-1:0] wState,
  output logic             trapValid,
  output logic [2:0]       trapKind,
  output logic             trapOther,
  output logic [WSW-1:0]   trapVec
);

  localparam bit POW2 = ((1 << CW) == NWIN);

  logic [CW-1:0]  cwpPlus1, cwpPlus2, cwpMinus1, cwpNext;
  logic [WSW-1:0] vecNext;

  // Pointer arithmetic: plain truncation when NWIN is a power of two,
  // compare-and-subtract otherwise.
  generate
    if (POW2) begin : g_wrap_pow2
      assign cwpPlus1  = cwp + CW'(1);
      assign cwpPlus2  = cwp + CW'(2);
      assign cwpMinus1 = cwp - CW'(1);
    end else begin : g_wrap_mod
      logic [CW:0] sum1, sum2;
      assign sum1      = {1'b0, cwp} + (CW+1)'(1);
      assign sum2      = {1'b0, cwp} + (CW+1)'(2);
      assign cwpPlus1  = (sum1 >= (CW+1)'(NWIN)) ? CW'(sum1 - (CW+1)'(NWIN)) : sum1[CW-1:0];
      assign cwpPlus2  = (sum2 >= (CW+1)'(NWIN)) ? CW'(sum2 - (CW+1)'(NWIN)) : sum2[CW-1:0];
      assign cwpMinus1 = (cwp == '0) ? CW'(NWIN - 1) : cwp - CW'(1);
    end
  endgenerate

  always_comb begin
    cwpNext = cwp;
    if (stb.cwpUp1)   cwpNext = cwpPlus1;
    if (stb.cwpUp2)   cwpNext = cwpPlus2;
    if (stb.cwpDown1) cwpNext = cwpMinus1;
  end

  always_comb begin
    vecNext = '0;
    if (stb.trapKind == TK_SPILL || stb.trapKind == TK_FILL)
      vecNext = stb.trapOther ? wState[2*WSW-1:WSW] : wState[WSW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp        <= '0;
      canSave    <= CW'(NWIN - 2);
      canRestore <= '0;
      cleanWin   <= CW'(NWIN - 1);
      otherWin   <= '0;
      wState     <= '0;
    end else begin
      cwp <= cwpNext;
      if (stb.shiftSave) begin
        canSave    <= canSave - CW'(1);
        canRestore <= canRestore + CW'(1);
      end
      if (stb.shiftRestore) begin
        canSave    <= canSave + CW'(1);
        canRestore <= canRestore - CW'(1);
      end
      if (stb.wrApply) begin
        unique case (wrSel_e'(wrSel))
          SEL_CWP:     cwp        <= wrData[CW-1:0];
          SEL_SAVE:    canSave    <= wrData[CW-1:0];
          SEL_RESTORE: canRestore <= wrData[CW-1:0];
          SEL_CLEAN:   cleanWin   <= wrData[CW-1:0];
          SEL_OTHER:   otherWin   <= wrData[CW-1:0];
          SEL_WSTATE:  wState     <= wrData[2*WSW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trapValid <= 1'b0;
      trapKind  <= TK_NONE;
      trapOther <= 1'b0;
      trapVec   <= '0;
    end else begin
      trapValid <= stb.trapFire;
      trapKind  <= stb.trapKind;
      trapOther <= stb.trapOther;
      trapVec   <= vecNext;
    end
  end

endmodule

// File: rtl/regwin_unit.sv
module regwin_unit
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int WSW  = 3,
  localparam int CW  = $clog2(NWIN),
  localparam int WDW = (CW > 2 * WSW) ? CW : 2 * WSW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [1:0]       retAddrLow,
  input  logic             wrEn,
  input  logic [2:0]       wrSel,
  input  logic [WDW-1:0]   wrData,
  output logic [CW-1:0]    cwp,
  output logic [CW-1:0]    canSave,
  output logic [CW-1:0]    canRestore,
  output logic [CW-1:0]    cleanWin,
  output logic [CW-1:0]    otherWin,
  output logic [2*WSW-1:0] wState,
  output logic             trapValid,
  output logic [2:0]       trapKind,
  output logic             trapOther,
  output logic [WSW-1:0]   trapVec
);

  winStrobe_t stb;

  regwin_ctrl #(.NWIN(NWIN)) u_ctrl (
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .retAddrLow (retAddrLow),
    .wrEn       (wrEn),
    .canSave    (canSave),
    .canRestore (canRestore),
    .cleanWin   (cleanWin),
    .otherWin   (otherWin),
    .stb        (stb)
  );

  regwin_dp #(.NWIN(NWIN), .WSW(WSW)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .wrSel      (wrSel),
    .wrData     (wrData),
    .cwp        (cwp),
    .canSave    (canSave),
    .canRestore (canRestore),
    .cleanWin   (cleanWin),
    .otherWin   (otherWin),
    .wState     (wState),
    .trapValid  (trapValid),
    .trapKind   (trapKind),
    .trapOther  (trapOther),
    .trapVec    (trapVec)
  );

  // R2
  save_step_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqOp == 2'd0 && canSave != '0 && cleanWin != canRestore) |=>
      (!trapValid && canSave == $past(canSave) - 1'b1 &&
       canRestore == $past(canRestore) + 1'b1));

  // R3
  spill_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqOp == 2'd0 && canSave == '0) |=>
      (trapValid && trapKind == 3'd1 &&
       cwp == CW'((int'($past(cwp)) + 2) % NWIN)));

  // R5
  fill_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqOp == 2'd1 && canRestore == '0) |=>
      (trapValid && trapKind == 3'd2 &&
       cwp == (($past(cwp) == '0) ? CW'(NWIN - 1) : $past(cwp) - 1'b1)));

  // R7
  misalign_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqOp == 2'd2 && retAddrLow != 2'b00) |=>
      (trapKind == 3'd4 && $stable(cwp) && $stable(canSave) && $stable(canRestore)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!reqValid && !wrEn) |=>
      ($stable(cwp) && $stable(canSave) && $stable(canRestore) && !trapValid));

  // R10
  trap_origin_chk: assert property (@(posedge clk) disable iff (rst)
    trapValid |-> $past(reqValid));

endmodule

// File: tb/sim_regwin_unit.sv
`timescale 1ns/1ps
module sim_regwin_unit;

  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reqValid = 1'b0;
  logic [1:0] reqOp = '0;
  logic [1:0] retAddrLow = '0;
  logic       wrEn = 1'b0;
  logic [2:0] wrSel = '0;
  logic [5:0] wrData = '0;
  logic [2:0] cwp, canSave, canRestore, cleanWin, otherWin;
  logic [5:0] wState;
  logic       trapValid, trapOther;
  logic [2:0] trapKind, trapVec;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  int mCwp = 0, mCs = N - 2, mCr = 0, mCl = N - 1, mOw = 0, mWs = 0;
  int eTv = 0, eK = 0, eO = 0, eVec = 0;

  always #2.5 clk = ~clk;

  regwin_unit u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp),
    .retAddrLow(retAddrLow), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .cwp(cwp), .canSave(canSave), .canRestore(canRestore),
    .cleanWin(cleanWin), .otherWin(otherWin), .wState(wState),
    .trapValid(trapValid), .trapKind(trapKind), .trapOther(trapOther),
    .trapVec(trapVec)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "cwp", int'(cwp), mCwp);
    chk(tag, "canSave", int'(canSave), mCs);
    chk(tag, "canRestore", int'(canRestore), mCr);
    chk(tag, "cleanWin", int'(cleanWin), mCl);
    chk(tag, "otherWin", int'(otherWin), mOw);
    chk(tag, "wState", int'(wState), mWs);
    chk(tag, "trapValid", int'(trapValid), eTv);
    chk(tag, "trapKind", int'(trapKind), eK);
    chk(tag, "trapOther", int'(trapOther), eO);
    chk(tag, "trapVec", int'(trapVec), eVec);
  endtask

  task automatic setTrap(input int kind);
    eTv = 1;
    eK  = kind;
    if (kind == 1 || kind == 2) begin
      eO   = (mOw != 0) ? 1 : 0;
      eVec = (eO != 0) ? ((mWs >> 3) & 7) : (mWs & 7);
    end
  endtask

  task automatic modelRestore();
    mCwp = (mCwp + N - 1) % N;
    if (mCr == 0) setTrap(2);
    else begin
      mCs = mCs + 1;
      mCr = mCr - 1;
    end
  endtask

  // Drive one cycle of stimulus, advance the model, compare one cycle later.
  task automatic step(input bit v, input int op, input int addr, input bit we,
                      input int sel, input int data, input string tag);
    reqValid   = v;
    reqOp      = 2'(op);
    retAddrLow = 2'(addr);
    wrEn       = we;
    wrSel      = 3'(sel);
    wrData     = 6'(data);
    eTv = 0; eK = 0; eO = 0; eVec = 0;
    if (v) begin
      case (op)
        0: begin
          if (mCs == 0) begin
            setTrap(1);
            mCwp = (mCwp + 2) % N;
          end else if (mCl == mCr) begin
            setTrap(3);
            mCwp = (mCwp + 1) % N;
          end else begin
            mCwp = (mCwp + 1) % N;
            mCs = mCs - 1;
            mCr = mCr + 1;
          end
        end
        1: modelRestore();
        2: if ((addr & 3) != 0) setTrap(4); else modelRestore();
        default: if ((N - 2 - mCs) != 0) setTrap(1);
      endcase
    end else if (we) begin
      case (sel)
        0: mCwp = data & 7;
        1: mCs  = data & 7;
        2: mCr  = data & 7;
        3: mCl  = data & 7;
        4: mOw  = data & 7;
        5: mWs  = data & 63;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 0, 0, 1'b0, 0, 0, tag);
  endtask

  task automatic wr(input int sel, input int data, input string tag);
    step(1'b0, 0, 0, 1'b1, sel, data, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R10 watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compareAll("R1");
    idle("R1");

    // R2: ordinary saves
    for (int i = 0; i < 3; i++) step(1'b1, 0, 0, 1'b0, 0, 0, "R2");
    // R5: ordinary restores then a fill with pointer wrap
    for (int i = 0; i < 3; i++) step(1'b1, 1, 0, 1'b0, 0, 0, "R5");
    step(1'b1, 1, 0, 1'b0, 0, 0, "R5");
    idle("R10");

    // R8: flush with windows outstanding, then with none
    wr(1, 3, "R9");
    step(1'b1, 3, 0, 1'b0, 0, 0, "R8");
    wr(1, N - 2, "R9");
    step(1'b1, 3, 0, 1'b0, 0, 0, "R8");

    // R3: spill with pointer wrap from the top window
    wr(0, 7, "R9");
    wr(1, 0, "R9");
    step(1'b1, 0, 0, 1'b0, 0, 0, "R3");
    idle("R10");

    // R6: spill using the other field, then the normal field
    wr(5, 6'b101011, "R9");
    wr(4, 2, "R9");
    step(1'b1, 0, 0, 1'b0, 0, 0, "R6");
    wr(4, 0, "R9");
    step(1'b1, 0, 0, 1'b0, 0, 0, "R6");
    // R6: fill typed as other
    wr(2, 0, "R9");
    wr(4, 1, "R9");
    step(1'b1, 1, 0, 1'b0, 0, 0, "R6");
    // R8: flush spill typed as other
    step(1'b1, 3, 0, 1'b0, 0, 0, "R8");

    // R4: clean-window trap
    wr(4, 0, "R9");
    wr(1, 3, "R9");
    wr(2, 2, "R9");
    wr(3, 2, "R9");
    step(1'b1, 0, 0, 1'b0, 0, 0, "R4");

    // R7: misaligned return, then aligned return
    step(1'b1, 2, 2, 1'b0, 0, 0, "R7");
    step(1'b1, 2, 1, 1'b0, 0, 0, "R7");
    step(1'b1, 2, 0, 1'b0, 0, 0, "R7");

    // R9: write ignored while a request is valid (flush with nothing to do)
    wr(1, N - 2, "R9");
    step(1'b1, 3, 0, 1'b1, 0, 5, "R9");
    wr(0, 0, "R9");
    step(1'b1, 0, 0, 1'b1, 2, 7, "R9");

    // R10: quiet cycles after activity
    idle("R10");
    idle("R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule